// File: doc/BRIEF.md
# SPI Slave Boot Byte Receiver with Host Hold-Off

This block sits between an external SPI master that streams a boot image and an on-chip image parser. The master shifts the image out one byte per transfer, most significant bit first, in SPI mode 0, and knows nothing about the structure of what it sends. The block oversamples the serial pins with the system clock and rebuilds each byte. It parks the byte in a one-entry holding register and offers it downstream over a valid/ready handshake.

Because the parser sometimes needs time without new input, the block drives a hold-off output toward the master. A high level tells the master to stop sending, and a low level lets it resume from where it paused. This happens while the parser works through a zero-fill block or runs an init routine, and also while the holding register is occupied. The hold-off line is one of a bank of general-purpose pins, chosen by a 4-bit index. Index 0 is reserved because that pin carries the slave select, so it never produces a hold-off. Hold-off is kept low from reset until the parser reports that its first block is complete. If a byte completes while the previous one is still waiting, the new byte is dropped and a sticky overrun flag is raised.

Top module: `spi_boot_rx`

## Requirements
- R1: Each byte is assembled from 8 MOSI bits sampled on rising SCK edges while the select is low. The first bit received becomes bit 7 of `rx_data`. The byte is then presented with `rx_valid` high.
- R2: Once `rx_valid` is high, it stays high and `rx_data` stays unchanged until a cycle in which `rx_ready` is high. In the cycle after that accept, `rx_valid` is low, unless a new byte completed in the accept cycle.
- R3: If a byte completes while `rx_valid` is high and `rx_ready` is low, the new byte is discarded and the held byte is kept. `overrun` then goes high and stays high until reset.
- R4: After arming, `hold_pins[hold_sel]` goes high on the clock edge after the one at which `dn_busy` is sampled high. It drops the same way once `dn_busy` is low and the holding register is empty.
- R5: After arming, `hold_pins[hold_sel]` is high on the clock edge after the one at which the holding register is seen occupied (`rx_valid` high).
- R6: From reset until the first `blk_done` pulse, every bit of `hold_pins` is low, whatever `dn_busy` and the holding register do.
- R7: At most one bit of `hold_pins` is high, and it is the bit whose index equals `hold_sel`. When `hold_sel` is 0, no bit is driven high.
- R8: Raising `spi_cs_n` discards any partly received byte. The next byte starts again at its first bit.
- R9: SCK edges that occur while `rst` is high produce no byte. After reset is released, `rx_valid` stays low until a full new byte arrives.
- R10: Reset leaves `rx_valid`, `overrun` and all of `hold_pins` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master, mode 0 |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low slave select |
| dn_busy | input | 1 | Parser is filling zeros or running init code |
| blk_done | input | 1 | One-cycle pulse when the parser finishes a block |
| hold_sel | input | 4 | Index of the pin used as the hold-off line |
| rx_ready | input | 1 | Parser accepts the offered byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Holding register occupied |
| overrun | output | 1 | Sticky flag for a dropped byte |
| hold_pins | output | 16 | General-purpose pin bank carrying the hold-off level |

## Verification
A rising SCK edge at the pins reaches the byte assembler after two synchronizer clocks. The completed byte is registered on the third clock edge, and `rx_valid` rises on the fourth. A hold-off pin follows its cause one clock edge after the cause is sampled, so `hold_pins` trails `rx_valid` by one more edge. The bench drives SCK with eight system clocks per half period and waits ten clocks after the last edge before sampling on a falling clock edge. That puts every check well past the four-edge latency and well before the next serial event. Hold-off checks are sampled three clocks after `dn_busy`, `hold_sel` or `rx_ready` change, which clears the one-edge latency with margin.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // synchronized serial pins
    typedef struct packed {
        logic sck;
        logic mosi;
        logic cs_n;
    } spi_pins_t;

    // completed-byte event from the assembler
    typedef struct packed {
        byte_t data;
        logic  done;
    } rx_evt_t;

    localparam spi_pins_t PINS_IDLE = '{sck: 1'b0, mosi: 1'b0, cs_n: 1'b1};

    function automatic logic rising(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/sbr_sync.sv
module sbr_sync
    import sbr_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  spi_pins_t pins_in,
    output spi_pins_t pins_out
);
    spi_pins_t chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) chain[i] <= PINS_IDLE;
        end else begin
            chain[0] <= pins_in;
            for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
        end
    end

    assign pins_out = chain[STAGES-1];
endmodule

// File: rtl/sbr_shifter.sv
module sbr_shifter
    import sbr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  spi_pins_t pins,
    output rx_evt_t   evt
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic             sck_prev;
    logic [CNT_W-1:0] bit_cnt;
    byte_t            shreg;
    byte_t            shnext;
    logic             sck_up;

    assign sck_up = rising(pins.sck, sck_prev);
    assign shnext = {shreg[BYTE_W-2:0], pins.mosi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            evt      <= '0;
        end else begin
            sck_prev <= pins.sck;
            evt.done <= 1'b0;
            if (pins.cs_n) begin
                bit_cnt <= '0;
            end else if (sck_up) begin
                shreg <= shnext;
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt  <= '0;
                    evt.done <= 1'b1;
                    evt.data <= shnext;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sbr_holding.sv
module sbr_holding
    import sbr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rx_evt_t evt,
    input  logic    ready,
    output byte_t   data,
    output logic    full,
    output logic    ovr
);
    logic take;

    assign take = full & ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            ovr  <= 1'b0;
            data <= '0;
        end else begin
            if (take) full <= 1'b0;
            if (evt.done) begin
                if (!full || take) begin
                    full <= 1'b1;
                    data <= evt.data;
                end else begin
                    ovr <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sbr_holdoff.sv
module sbr_holdoff #(
    parameter int unsigned PIN_CNT = 16,
    localparam int unsigned SEL_W = $clog2(PIN_CNT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               blk_done,
    input  logic               dn_busy,
    input  logic               full,
    input  logic [SEL_W-1:0]   sel,
    output logic [PIN_CNT-1:0] pins
);
    logic               armed;
    logic               want;
    logic [PIN_CNT-1:0] decoded;

    assign want = armed & (dn_busy | full);

    // pin 0 doubles as slave select and never carries hold-off
    assign decoded[0] = 1'b0;
    for (genvar g = 1; g < int'(PIN_CNT); g++) begin : g_pin
        assign decoded[g] = want && (sel == SEL_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            pins  <= '0;
        end else begin
            if (blk_done) armed <= 1'b1;
            pins <= decoded;
        end
    end
endmodule

// File: rtl/spi_boot_rx.sv
module spi_boot_rx
    import sbr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PIN_CNT     = 16,
    localparam int unsigned SEL_W      = $clog2(PIN_CNT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               spi_sck,
    input  logic               spi_mosi,
    input  logic               spi_cs_n,
    input  logic               dn_busy,
    input  logic               blk_done,
    input  logic [SEL_W-1:0]   hold_sel,
    input  logic               rx_ready,
    output logic [BYTE_W-1:0]  rx_data,
    output logic               rx_valid,
    output logic               overrun,
    output logic [PIN_CNT-1:0] hold_pins
);
    spi_pins_t raw_pins;
    spi_pins_t sync_pins;
    rx_evt_t   evt;

    assign raw_pins = '{sck: spi_sck, mosi: spi_mosi, cs_n: spi_cs_n};

    sbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pins_in  (raw_pins),
        .pins_out (sync_pins)
    );

    sbr_shifter u_shift (
        .clk  (clk),
        .rst  (rst),
        .pins (sync_pins),
        .evt  (evt)
    );

    sbr_holding u_hold (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .ready (rx_ready),
        .data  (rx_data),
        .full  (rx_valid),
        .ovr   (overrun)
    );

    sbr_holdoff #(.PIN_CNT(PIN_CNT)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .blk_done (blk_done),
        .dn_busy  (dn_busy),
        .full     (rx_valid),
        .sel      (hold_sel),
        .pins     (hold_pins)
    );
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
    parameter int unsigned PIN_CNT = 16,
    localparam int unsigned SEL_W  = $clog2(PIN_CNT)
) (
    input logic               clk,
    input logic               rst,
    input logic               dn_busy,
    input logic               blk_done,
    input logic [SEL_W-1:0]   hold_sel,
    input logic               rx_ready,
    input logic [7:0]         rx_data,
    input logic               rx_valid,
    input logic               overrun,
    input logic [PIN_CNT-1:0] hold_pins
);
    logic seen;

    always_ff @(posedge clk) begin
        if (rst)           seen <= 1'b0;
        else if (blk_done) seen <= 1'b1;
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R2

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R3

    AST_BUSY_WAIT: assert property (@(posedge clk) disable iff (rst)
        seen && dn_busy && hold_sel != '0 |=> hold_pins[$past(hold_sel)]); // R4

    AST_FULL_WAIT: assert property (@(posedge clk) disable iff (rst)
        seen && rx_valid && hold_sel != '0 |=> hold_pins[$past(hold_sel)]); // R5

    AST_QUIET_UNARMED: assert property (@(posedge clk) disable iff (rst)
        !seen |-> hold_pins == '0); // R6

    AST_ONE_PIN: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hold_pins)); // R7

    AST_PIN0_IDLE: assert property (@(posedge clk) disable iff (rst)
        !hold_pins[0]); // R7
endmodule

bind spi_boot_rx sbr_checker #(.PIN_CNT(PIN_CNT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dn_busy   (dn_busy),
    .blk_done  (blk_done),
    .hold_sel  (hold_sel),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .overrun   (overrun),
    .hold_pins (hold_pins)
);

// File: tb/sim_spi_boot_rx.sv
module sim_spi_boot_rx;
    logic        clk = 1'b0;
    logic        rst;
    logic        spi_sck, spi_mosi, spi_cs_n;
    logic        dn_busy, blk_done, rx_ready;
    logic [3:0]  hold_sel;
    logic [7:0]  rx_data;
    logic        rx_valid, overrun;
    logic [15:0] hold_pins;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    localparam int HALF = 8;
    // {hold cycles before accept, byte}
    localparam logic [11:0] VEC [6] = '{12'h2A5, 12'h03C, 12'h501, 12'h180, 12'h3FF, 12'h000};

    always #10 clk = ~clk;

    spi_boot_rx u0 (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .dn_busy(dn_busy), .blk_done(blk_done),
        .hold_sel(hold_sel), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .overrun(overrun), .hold_pins(hold_pins)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            spi_mosi = b[i];
            cyc(HALF);
            spi_sck = 1'b1;
            cyc(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        spi_cs_n = 1'b0;
        cyc(HALF);
        send_bits(b, 8);
        cyc(HALF);
        spi_cs_n = 1'b1;
        cyc(10);
    endtask

    task automatic accept();
        rx_ready = 1'b1;
        cyc(1);
        rx_ready = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(4);
        rst = 1'b0;
        cyc(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; spi_sck = 1'b0; spi_mosi = 1'b0; spi_cs_n = 1'b1;
        dn_busy = 1'b0; blk_done = 1'b0; rx_ready = 1'b0; hold_sel = 4'd4;
        cyc(4);

        // R9: a full byte clocked while reset is held is lost
        spi_cs_n = 1'b0;
        send_bits(8'hC3, 8);
        spi_cs_n = 1'b1;
        // R10: reset state
        chk("R10 rx_valid", rx_valid, 0);
        chk("R10 overrun", overrun, 0);
        chk("R10 hold_pins", hold_pins, 0);
        rst = 1'b0;
        cyc(12);
        chk("R9 no byte from reset", rx_valid, 0);

        // R1/R2: table walk
        for (int i = 0; i < 6; i++) begin
            send_byte(VEC[i][7:0]);
            chk("R1 valid", rx_valid, 1);
            chk("R1 data", rx_data, VEC[i][7:0]);
            cyc(int'(VEC[i][11:8]));
            chk("R2 held valid", rx_valid, 1);
            chk("R2 held data", rx_data, VEC[i][7:0]);
            accept();
            chk("R2 cleared after accept", rx_valid, 0);
        end

        // R3: overrun keeps first byte
        send_byte(8'h6E);
        chk("R3 no overrun yet", overrun, 0);
        send_byte(8'h91);
        chk("R3 overrun set", overrun, 1);
        chk("R3 first byte kept", rx_data, 8'h6E);
        accept();
        cyc(3);
        chk("R3 dropped byte absent", rx_valid, 0);
        chk("R3 overrun sticky", overrun, 1);
        do_reset();
        chk("R10 overrun cleared", overrun, 0);

        // R8: partial byte discarded on select release
        spi_cs_n = 1'b0;
        cyc(HALF);
        send_bits(8'hF0, 4);
        spi_cs_n = 1'b1;
        cyc(12);
        chk("R8 no partial byte", rx_valid, 0);
        send_byte(8'h5A);
        chk("R8 fresh byte", rx_data, 8'h5A);
        accept();

        // R6: not armed yet
        dn_busy = 1'b1;
        cyc(6);
        chk("R6 quiet while busy", hold_pins, 0);
        dn_busy = 1'b0;
        send_byte(8'h33);
        chk("R6 quiet while full", hold_pins, 0);
        accept();

        // arm
        blk_done = 1'b1;
        cyc(1);
        blk_done = 1'b0;
        cyc(2);
        chk("R4 idle after arm", hold_pins, 0);
        dn_busy = 1'b1;
        cyc(3);
        chk("R4 busy raises pin 4", hold_pins, 16'h0010);
        dn_busy = 1'b0;
        cyc(3);
        chk("R4 released", hold_pins, 0);

        // R7: selection
        dn_busy = 1'b1;
        hold_sel = 4'd0;
        cyc(3);
        chk("R7 index 0 silent", hold_pins, 0);
        hold_sel = 4'd9;
        cyc(3);
        chk("R7 pin 9", hold_pins, 16'h0200);
        hold_sel = 4'd15;
        cyc(3);
        chk("R7 pin 15", hold_pins, 16'h8000);
        dn_busy = 1'b0;
        hold_sel = 4'd4;
        cyc(3);

        // R5: full holding register raises hold-off
        send_byte(8'hC7);
        chk("R5 full raises pin", hold_pins, 16'h0010);
        accept();
        cyc(3);
        chk("R5 released after accept", hold_pins, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule